// File: doc/BRIEF.md
# Periodic / One-Shot Compare Channel

One channel of a free-running timer block. It watches the shared 32-bit main count that a neighbouring register file supplies. When that count equals the channel's compare point while counting is enabled, the channel emits a single-cycle fire pulse. The channel has two modes. In one-shot mode the compare point stays where software put it. In periodic mode the channel moves the compare point forward by a programmed period after each hit.

The register file passes in two write strobes. One carries a full 64-bit configuration word and the other a comparator word. A control bit in the configuration decides what a periodic comparator write does. When the bit is set, the write moves the compare point as well as the period. When it is clear, the write changes only the period. The bit clears itself after every accepted comparator write.

When the count has already run past the compare point, the channel does not fire once for every missed period. It rounds the compare point up to the first period boundary ahead of the count. A sequential remainder divider performs this step. While the divider works, the channel reports busy and does not detect matches.

Top module: `cmp_channel`

## Requirements
- R1: After reset the compare point reads 0xFFFFFFFF, the period reads 0, the configuration reads 0x00F00000_00008010, and fire and busy are low.
- R2: A configuration write updates only bits 1, 2, 3, 6 and 9..14. Bits 63:32 (allowed-route mask), 15 (message-delivery capable), 5 (size capability, 0 = 32-bit count) and 4 (periodic capable) are read-only. Bit 8 and all other bits always read 0.
- R3: In periodic mode (configuration bit 3 = 1), a comparator write with the value-set bit (bit 6) at 1 loads both the period and the compare point with the written value.
- R4: In periodic mode, a comparator write with the value-set bit at 0 loads the period and leaves the compare point unchanged.
- R5: In one-shot mode (bit 3 = 0), a comparator write loads the compare point only, and the period stays 0.
- R6: The value-set bit reads 0 after any accepted comparator write.
- R7: A configuration write with bit 3 = 0 forces the period to 0. It also cancels a reload in progress, so busy is low in the following cycle and the compare point keeps its value.
- R8: fire_o goes high for exactly one cycle, in the cycle after the first cycle in which the counter is enabled, the count equals the compare point and the channel is not busy. No further pulse follows while that equality persists, and no pulse occurs while counting is disabled.
- R9: A fire in periodic mode with a nonzero period starts a reload. Busy stays high for exactly W+1 = 33 cycles, and then the compare point equals the old compare point plus the period.
- R10: In periodic mode with a nonzero resulting period, a reload also starts when a comparator write is accepted while the counter is enabled, or when the counter enable rises. With C the count at that moment and M the compare point after the write, the new compare point is C + P − ((C − M) mod P), computed modulo 2^32.
- R11: No fire pulse occurs while busy is high, even if the count equals the old compare point.
- R12: In one-shot mode no catch-up is applied. A compare point below the count does not fire until the count equals it, and the compare point does not change after a fire.
- R13: In periodic mode with a period of 0, a fire starts no reload: busy stays low and the compare point is unchanged.
- R14: A comparator write in the same cycle as a configuration write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 32 | Shared main count value |
| count_en_i | input | 1 | Main count is running |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 64 | Configuration write data |
| cmp_wr_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | 32 | Comparator write data |
| cfg_o | output | 64 | Current configuration word |
| cmp_o | output | 32 | Current compare point |
| period_o | output | 32 | Current period |
| fire_o | output | 1 | One-cycle match pulse |
| busy_o | output | 1 | Reload in progress, matching suspended |

## Verification
A wrong remainder or a wrong captured count appears on cmp_o in the cycle after busy_o falls, W+1 cycles after the trigger, as a compare point that is not within one period ahead of the count. A stuck match history or a stuck busy shows on fire_o one cycle after the count reaches the compare point, either as a missing pulse or as a repeated one. An error in the configuration mask or in the value-set handling appears on cfg_o, cmp_o or period_o in the cycle right after the write.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;
  localparam int CFG_W  = 64;
  // configuration bit positions
  localparam int B_MODE = 3;   // 1 = periodic
  localparam int B_PCAP = 4;   // periodic capable, read-only
  localparam int B_SCAP = 5;   // 64-bit count capable, read-only 0
  localparam int B_VSET = 6;   // value-set control
  localparam int B_W32  = 8;   // 32-bit mode select, forced 0
  localparam int B_MCAP = 15;  // message delivery capable, read-only
  // bits software may change: 1,2,3,6,9..14
  localparam logic [CFG_W-1:0] CFG_WMASK = 64'h0000_0000_0000_7E4E;

  function automatic logic [CFG_W-1:0] cfg_reset_val(input logic [31:0] route_mask);
    logic [CFG_W-1:0] v;
    v         = '0;
    v[63:32]  = route_mask;
    v[B_PCAP] = 1'b1;
    v[B_MCAP] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cmp_cfg_reg.sv
module cmp_cfg_reg
  import cmp_chan_pkg::*;
#(
  parameter logic [31:0] ROUTE_MASK = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             vs_clr_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam logic [CFG_W-1:0] RST_VAL = cfg_reset_val(ROUTE_MASK);

  logic [CFG_W-1:0] cfg_q, cfg_n;
  logic             cfg_en;

  assign cfg_en = wr_i | vs_clr_i;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_i) cfg_n = (cfg_q & ~CFG_WMASK) | (wdata_i & CFG_WMASK);
    if (vs_clr_i) cfg_n[B_VSET] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (cfg_en) cfg_q <= cfg_n;
  end

  assign cfg_o = cfg_q;

  // R2: capability fields never move once out of reset
  a_r2_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable({cfg_q[63:32], cfg_q[B_MCAP], cfg_q[B_SCAP], cfg_q[B_PCAP]}));
  // R2: 32-bit mode select stays low after any write
  a_r2_w32_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !cfg_q[B_W32]);
  // R6: value-set self-clears after an accepted comparator write
  a_r6_vset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vs_clr_i |=> !cfg_q[B_VSET]);
endmodule

// File: rtl/cmp_rem_div.sv
module cmp_rem_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  dvd_q, dvd_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [W-1:0]  rem_q, rem_n;
  logic [W:0]    trial, diff;

  assign trial = {rem_q, dvd_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    dvd_n  = dvd_q;
    dvs_n  = dvs_q;
    rem_n  = rem_q;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = CW'(W);
      dvd_n  = dvd_i;
      dvs_n  = dvs_i;
      rem_n  = '0;
    end else if (abort_i) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      rem_n = (trial >= {1'b0, dvs_q}) ? diff[W-1:0] : trial[W-1:0];
      dvd_n = dvd_q << 1;
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      dvd_q  <= dvd_n;
      dvs_q  <= dvs_n;
      rem_q  <= rem_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rem_o  = rem_q;

  // R9: a finished remainder is always below the divisor
  a_r9_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dvs_q));
  // R9: done and busy are never high together
  a_r9_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] cmp_i,
  input  logic         count_en_i,
  input  logic         block_i,
  output logic         rise_o,
  output logic         fire_o
);
  logic hit, hit_q, fire_q;

  assign hit    = count_en_i & (count_i == cmp_i) & ~block_i;
  assign rise_o = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      hit_q  <= hit;
      fire_q <= rise_o;
    end
  end

  assign fire_o = fire_q;

  // R8: the pulse lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  // R11: a busy cycle never produces a pulse
  a_r11_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |=> !fire_o);
  // R8: a disabled counter never produces a pulse
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en_i |=> !fire_o);
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_chan_pkg::*;
#(
  parameter int          W          = 32,
  parameter logic [31:0] ROUTE_MASK = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     count_i,
  input  logic             count_en_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             cmp_wr_i,
  input  logic [W-1:0]     cmp_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [W-1:0]     cmp_o,
  output logic [W-1:0]     period_o,
  output logic             fire_o,
  output logic             busy_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [W-1:0]     cmp_q, cmp_n, period_q, period_n, cap_q, cap_n;
  logic [W-1:0]     wr_cmp, wr_per, dvd, dvs, div_rem;
  logic             periodic, vset, cmp_acc, leave_per, en_q, en_rise;
  logic             hit_rise, start_wr, start_run, start, abort;
  logic             div_busy, div_done, reload_ok, upd;

  assign periodic  = cfg_q[B_MODE];
  assign vset      = cfg_q[B_VSET];
  assign cmp_acc   = cmp_wr_i & ~cfg_wr_i;
  assign leave_per = cfg_wr_i & ~cfg_wdata_i[B_MODE];

  // effect of an accepted comparator write
  assign wr_cmp = (periodic & ~vset) ? cmp_q : cmp_wdata_i;
  assign wr_per = periodic ? cmp_wdata_i : '0;

  assign en_rise   = count_en_i & ~en_q;
  assign start_wr  = cmp_acc & periodic & (cmp_wdata_i != '0) & count_en_i;
  assign start_run = (hit_rise | en_rise) & periodic & (period_q != '0)
                     & ~leave_per & ~cmp_acc;
  assign start     = start_wr | start_run;
  assign abort     = leave_per | cmp_acc;
  assign dvd       = count_i - (cmp_acc ? wr_cmp : cmp_q);
  assign dvs       = cmp_acc ? wr_per : period_q;
  assign reload_ok = div_done & ~cmp_acc & ~leave_per;
  assign upd       = reload_ok | cmp_acc | leave_per;
  assign busy_o    = div_busy | div_done;

  cmp_cfg_reg #(.ROUTE_MASK(ROUTE_MASK)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cfg_wr_i),
    .wdata_i  (cfg_wdata_i),
    .vs_clr_i (cmp_acc),
    .cfg_o    (cfg_q)
  );

  cmp_match #(.W(W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .cmp_i      (cmp_q),
    .count_en_i (count_en_i),
    .block_i    (busy_o),
    .rise_o     (hit_rise),
    .fire_o     (fire_o)
  );

  cmp_rem_div #(.W(W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .abort_i (abort),
    .dvd_i   (dvd),
    .dvs_i   (dvs),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .rem_o   (div_rem)
  );

  always_comb begin
    cmp_n    = cmp_q;
    period_n = period_q;
    if (reload_ok) cmp_n = cap_q + period_q - div_rem;
    if (cmp_acc) begin
      cmp_n    = wr_cmp;
      period_n = wr_per;
    end
    if (leave_per) period_n = '0;
    cap_n = start ? count_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '1;
      period_q <= '0;
    end else if (upd) begin
      cmp_q    <= cmp_n;
      period_q <= period_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_q <= '0;
    else if (start) cap_q <= cap_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= count_en_i;
  end

  assign cfg_o    = cfg_q;
  assign cmp_o    = cmp_q;
  assign period_o = period_q;

  // R5: one-shot mode always shows a zero period
  a_r5_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[B_MODE] |-> (period_q == '0));
  // R9/R10: a completed reload lands within one period ahead of the captured count
  a_r9_reload_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_ok & ~start) |=> ((cmp_q - cap_q - W'(1)) < period_q));
  // R7: leaving periodic mode stops any reload
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    leave_per |=> !busy_o);
endmodule

// File: tb/tb_cmp_channel.sv
module tb_cmp_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [31:0] count;
  logic        count_en, cfg_wr, cmp_wr;
  logic [63:0] cfg_wdata;
  logic [31:0] cmp_wdata;
  logic [63:0] cfg_o;
  logic [31:0] cmp_o, period_o;
  logic        fire_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  cmp_channel dut (
    .clk(clk), .rst_n(rst_n), .count_i(count), .count_en_i(count_en),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cmp_wr_i(cmp_wr),
    .cmp_wdata_i(cmp_wdata), .cfg_o(cfg_o), .cmp_o(cmp_o),
    .period_o(period_o), .fire_o(fire_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_reload(input logic [31:0] c, input logic [31:0] m,
                                             input logic [31:0] p);
    logic [31:0] d;
    d = c - m;
    return c + p - (d % p);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; count = '0; count_en = 1'b0;
    cfg_wr = 1'b0; cfg_wdata = '0; cmp_wr = 1'b0; cmp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [63:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr_cmp(input logic [31:0] d);
    @(negedge clk); cmp_wr = 1'b1; cmp_wdata = d;
    @(negedge clk); cmp_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy_o && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cfg", cfg_o, 64'h00F0_0000_0000_8010);
    chk("R1 cmp", {32'h0, cmp_o}, 64'hFFFF_FFFF);
    chk("R1 period", {32'h0, period_o}, 64'h0);
    chk("R1 fire/busy", {62'h0, fire_o, busy_o}, 64'h0);
  endtask

  task automatic t_cfg_mask();
    do_reset();
    wr_cfg('1);
    chk("R2 all ones", cfg_o, 64'h00F0_0000_0000_FE5E);
    wr_cfg('0);
    chk("R2 all zeros", cfg_o, 64'h00F0_0000_0000_8010);
  endtask

  task automatic t_oneshot();
    do_reset();
    wr_cmp(32'd50);
    chk("R5 cmp", {32'h0, cmp_o}, 64'd50);
    chk("R5 period", {32'h0, period_o}, 64'd0);
    @(negedge clk); count = 32'd100; count_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R12 past point no fire", {63'h0, fire_o}, 64'd0);
    end
    count = 32'd50;
    @(negedge clk);
    chk("R8 fire on match", {63'h0, fire_o}, 64'd1);
    repeat (3) begin
      @(negedge clk);
      chk("R8 single pulse", {63'h0, fire_o}, 64'd0);
    end
    chk("R12 no reload", {32'h0, cmp_o}, 64'd50);
    chk("R12 not busy", {63'h0, busy_o}, 64'd0);
    count_en = 1'b0; count = 32'd49;
    @(negedge clk); count = 32'd50;
    repeat (2) begin
      @(negedge clk);
      chk("R8 disabled no fire", {63'h0, fire_o}, 64'd0);
    end
  endtask

  task automatic t_valset();
    do_reset();
    wr_cfg(64'h48);
    wr_cmp(32'd300);
    chk("R3 cmp", {32'h0, cmp_o}, 64'd300);
    chk("R3 period", {32'h0, period_o}, 64'd300);
    chk("R6 vset clear", {63'h0, cfg_o[6]}, 64'd0);
    wr_cmp(32'd700);
    chk("R4 cmp kept", {32'h0, cmp_o}, 64'd300);
    chk("R4 period", {32'h0, period_o}, 64'd700);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 64'h48; cmp_wr = 1'b1; cmp_wdata = 32'd999;
    @(negedge clk);
    cfg_wr = 1'b0; cmp_wr = 1'b0;
    chk("R14 cmp ignored", {32'h0, cmp_o}, 64'd300);
    chk("R14 period ignored", {32'h0, period_o}, 64'd700);
    chk("R14 vset kept", {63'h0, cfg_o[6]}, 64'd1);
  endtask

  task automatic t_leave();
    do_reset();
    @(negedge clk); count = 32'd5000; count_en = 1'b1;
    wr_cfg(64'h48);
    wr_cmp(32'd1234);
    chk("R10 write starts reload", {63'h0, busy_o}, 64'd1);
    wr_cfg(64'h0);
    chk("R7 reload cancelled", {63'h0, busy_o}, 64'd0);
    chk("R7 period zero", {32'h0, period_o}, 64'd0);
    chk("R7 cmp kept", {32'h0, cmp_o}, 64'd1234);
  endtask

  task automatic t_catchup();
    logic [31:0] c;
    do_reset();
    @(negedge clk); count = 32'd5000; count_en = 1'b1;
    wr_cfg(64'h48);
    wr_cmp(32'd1234);
    wait_idle();
    chk("R10 catch-up value", {32'h0, cmp_o}, {32'h0, exp_reload(32'd5000, 32'd1234, 32'd1234)});
    chk("R10 ahead of count", {63'h0, ((cmp_o - 32'd5001) < 32'd1234)}, 64'd1);
    c = cmp_o;
    wr_cmp(32'd256);
    wait_idle();
    chk("R10 period-only write", {32'h0, period_o}, 64'd256);
    chk("R10 second catch-up", {32'h0, cmp_o}, {32'h0, exp_reload(32'd5000, c, 32'd256)});
  endtask

  task automatic t_reload();
    logic [31:0] x;
    int nb = 0;
    bit seen = 0;
    do_reset();
    wr_cfg(64'h48);
    wr_cmp(32'd1000);
    @(negedge clk); count = 32'd400; count_en = 1'b1;
    @(negedge clk);
    chk("R10 enable rise starts reload", {63'h0, busy_o}, 64'd1);
    wait_idle();
    chk("R10 enable rise value", {32'h0, cmp_o}, {32'h0, exp_reload(32'd400, 32'd1000, 32'd1000)});
    x = cmp_o;
    count = x;
    @(negedge clk);
    chk("R9 periodic fire", {63'h0, fire_o}, 64'd1);
    while (busy_o && nb < 100) begin
      nb++;
      if (nb > 1 && fire_o) seen = 1;
      count = (nb == 1) ? x + 32'd1 : x;
      @(negedge clk);
    end
    chk("R11 no fire while busy", {63'h0, seen}, 64'd0);
    chk("R9 busy span", nb, 64'd33);
    chk("R9 reload value", {32'h0, cmp_o}, {32'h0, x + 32'd1000});
    count = x + 32'd1000;
    @(negedge clk);
    chk("R9 next period fires", {63'h0, fire_o}, 64'd1);
    wait_idle();
  endtask

  task automatic t_pzero();
    do_reset();
    wr_cmp(32'd200);
    wr_cfg(64'h8);
    chk("R13 period zero", {32'h0, period_o}, 64'd0);
    @(negedge clk); count = 32'd200; count_en = 1'b1;
    @(negedge clk);
    chk("R13 fire", {63'h0, fire_o}, 64'd1);
    chk("R13 no busy", {63'h0, busy_o}, 64'd0);
    @(negedge clk);
    chk("R13 cmp kept", {32'h0, cmp_o}, 64'd200);
    chk("R13 still idle", {63'h0, busy_o}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg_mask();
    t_oneshot();
    t_valset();
    t_leave();
    t_catchup();
    t_reload();
    t_pzero();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule